// File: doc/BRIEF.md
# Deserializing ROM Multi-Word Fetcher

The block reads a run of consecutive words out of one small lookup table and returns them together on a wide output. The table is a single-port ROM whose output register updates on the rising clock edge. It can therefore deliver only one word per clock. A single table port is enough, so the block does not need duplicated or interleaved copies of the table. Instead, a cyclic state machine uses both edges of one clock. On falling edges it places the next table address. On rising edges it takes the word the ROM has registered and writes it into its slot in the result.

The user pulses a start input together with a base address. Word i of the result is read from table address base+i, and the address wraps at the top of the 16-entry table. After all K words have been collected, they appear side by side on the result output, with word 0 in the least significant byte. A one-cycle valid strobe marks the new result. The result output then keeps that value until the next fetch completes.

Top module: `dsr_fetch`

## Requirements
- R1: The internal 8-bit table holds 0x0E at address 1, 0x2D at 2, 0x43 at 3, 0x20 at 4, 0x0C at 5 and 0x40 at 6. Every other address of the 16 holds 0x00.
- R2: A fetch started with base b places the table word at address (b+i) mod 16 in bits [8i+7:8i] of result_o, for i = 0..K-1 (K defaults to 4).
- R3: valid_o goes high for exactly one cycle. It is visible after the (K+1)-th rising edge that follows the rising edge that sampled start_i high while the block was idle.
- R4: result_o changes only at the edge that raises valid_o. Between two valid pulses it holds its value.
- R5: A start_i pulse sampled while a fetch is in progress is ignored. It produces no extra valid pulse, and the result still comes from the original base.
- R6: A synchronous active-high reset sets result_o to zero, drops valid_o, aborts any running fetch and returns the block to idle.
- R7: The block is idle again once valid_o is high. A start_i sampled at the next rising edge begins a new fetch, with the same latency as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; both edges are used |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, sampled on rising edges |
| base_i | input | AW (4) | First table address of the request |
| result_o | output | K*DW (32) | Collected words, word 0 in the low byte |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench compares each fetch with a table model of its own. The directed cases include bases 14 and 15, where the address must wrap: a design that dropped the carry wrongly or mis-sized the adder would return the wrong upper bytes. Start pulses are injected at every point of a running fetch. A design that accepted them would re-latch the base, return mixed words or raise a second valid pulse. The bench also measures the latency and the width of the strobe exactly, applies reset in the middle of a fetch, and issues back-to-back requests right after valid. Together these catch a wrong pairing of the edges, an off-by-one in the capture slot, a lost final word, or a block that stays busy after it finishes.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  localparam int TBL_DW = 8;

  // Constant table: only addresses 1..6 carry data.
  function automatic logic [TBL_DW-1:0] rom_word(input int unsigned a);
    logic [TBL_DW-1:0] w;
    case (a)
      1:       w = 8'h0E;
      2:       w = 8'h2D;
      3:       w = 8'h43;
      4:       w = 8'h20;
      5:       w = 8'h0C;
      6:       w = 8'h40;
      default: w = 8'h00;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/dsr_rom.sv
module dsr_rom #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] q_o
);
  // Registered output on the rising edge: one word per clock.
  always_ff @(posedge clk_i) begin
    q_o <= DW'(dsr_pkg::rom_word(int'(unsigned'(addr_i))));
  end
endmodule

// File: rtl/dsr_issue.sv
module dsr_issue #(
  parameter int K  = 4,
  parameter int AW = 4,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          run_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] addr_o,
  output logic          iss_v_o,
  output logic [IW-1:0] iss_idx_o
);
  localparam logic [IW-1:0] LAST_CNT = IW'(K);

  logic [IW-1:0] cnt_q;

  // Falling-edge half of the cyclic machine: one address per clock.
  always_ff @(negedge clk_i) begin
    if (rst_i) begin
      cnt_q     <= '0;
      addr_o    <= '0;
      iss_v_o   <= 1'b0;
      iss_idx_o <= '0;
    end else if (run_i && cnt_q != LAST_CNT) begin
      addr_o    <= base_i + AW'(cnt_q);
      iss_idx_o <= cnt_q;
      iss_v_o   <= 1'b1;
      cnt_q     <= cnt_q + 1'b1;
    end else begin
      iss_v_o <= 1'b0;
      if (!run_i) cnt_q <= '0;
    end
  end
endmodule

// File: rtl/dsr_gather.sv
module dsr_gather #(
  parameter int K  = 4,
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int IW = 3
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic            iss_v_i,
  input  logic [IW-1:0]   iss_idx_i,
  input  logic [DW-1:0]   rom_q_i,
  output logic            run_o,
  output logic [AW-1:0]   base_o,
  output logic [K*DW-1:0] result_o,
  output logic            valid_o
);
  localparam logic [IW-1:0] LAST_IDX = IW'(K - 1);

  logic            dv_q;
  logic [IW-1:0]   didx_q;
  logic [K*DW-1:0] work_q;
  logic [K*DW-1:0] work_nxt;
  logic            last_w;

  always_comb begin
    work_nxt = work_q;
    for (int i = 0; i < K; i++) begin
      if (dv_q && didx_q == IW'(i)) work_nxt[i*DW +: DW] = rom_q_i;
    end
  end

  assign last_w = dv_q && (didx_q == LAST_IDX);

  // Rising-edge half: capture the registered ROM word into its slot.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_o    <= 1'b0;
      base_o   <= '0;
      dv_q     <= 1'b0;
      didx_q   <= '0;
      work_q   <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      dv_q    <= iss_v_i;
      didx_q  <= iss_idx_i;
      if (dv_q) work_q <= work_nxt;
      if (last_w) begin
        result_o <= work_nxt;
        valid_o  <= 1'b1;
        run_o    <= 1'b0;
      end else if (start_i && !run_o) begin
        run_o  <= 1'b1;
        base_o <= base_i;
      end
    end
  end
endmodule

// File: rtl/dsr_fetch.sv
module dsr_fetch #(
  parameter int K  = 4,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  output logic [K*DW-1:0] result_o,
  output logic            valid_o
);
  localparam int IW = $clog2(K + 1);

  logic          run_w;
  logic [AW-1:0] base_w;
  logic [AW-1:0] addr_w;
  logic          iss_v_w;
  logic [IW-1:0] iss_idx_w;
  logic [DW-1:0] rom_q_w;

  dsr_issue #(.K(K), .AW(AW), .IW(IW)) u_issue (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(run_w), .base_i(base_w),
    .addr_o(addr_w), .iss_v_o(iss_v_w), .iss_idx_o(iss_idx_w)
  );

  dsr_rom #(.AW(AW), .DW(DW)) u_rom (
    .clk_i(clk_i), .addr_i(addr_w), .q_o(rom_q_w)
  );

  dsr_gather #(.K(K), .AW(AW), .DW(DW), .IW(IW)) u_gather (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .base_i(base_i),
    .iss_v_i(iss_v_w), .iss_idx_i(iss_idx_w), .rom_q_i(rom_q_w),
    .run_o(run_w), .base_o(base_w), .result_o(result_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/dsr_fetch_chk.sv
module dsr_fetch_chk #(
  parameter int K  = 4,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic            start_i,
  input logic            run_w,
  input logic [AW-1:0]   base_w,
  input logic [K*DW-1:0] result_o,
  input logic            valid_o
);
  logic rst_d = 1'b1;
  always_ff @(posedge clk_i) rst_d <= rst_i;

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);

  a_r7_idle_at_valid: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> !run_w);

  a_r3_end_gives_valid: assert property (@(posedge clk_i) disable iff (rst_i || rst_d)
    $fell(run_w) |-> valid_o);

  a_r4_hold_result: assert property (@(posedge clk_i) disable iff (rst_i || rst_d)
    !valid_o |-> $stable(result_o));

  a_r5_ignore_busy_start: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_w && start_i) |=> $stable(base_w));

  a_r6_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (!valid_o && result_o == '0));
endmodule

bind dsr_fetch dsr_fetch_chk #(.K(K), .AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .run_w(run_w),
  .base_w(base_w), .result_o(result_o), .valid_o(valid_o)
);

// File: tb/sim_dsr_fetch.sv
`timescale 1ns/1ps
module sim_dsr_fetch;
  localparam int K  = 4;
  localparam int AW = 4;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [AW-1:0]   base = '0;
  logic [K*DW-1:0] result;
  logic            valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dsr_fetch #(.K(K), .AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_i(rst), .start_i(start), .base_i(base),
    .result_o(result), .valid_o(valid)
  );

  function automatic logic [7:0] ref_word(input int a);
    case (a)
      1: return 8'h0E;
      2: return 8'h2D;
      3: return 8'h43;
      4: return 8'h20;
      5: return 8'h0C;
      6: return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [K*DW-1:0] ref_result(input int b);
    logic [K*DW-1:0] r = '0;
    for (int i = 0; i < K; i++) r[i*DW +: DW] = ref_word((b + i) % 16);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  // One fetch; optional busy start injected in cycle inj_at.
  task automatic run_fetch(input int b, input bit inject, input int inj_at, input string tag);
    int n = 0;
    bit got = 0;
    logic [K*DW-1:0] exp = ref_result(b);
    base = AW'(b);
    start = 1'b1;
    tick();
    start = 1'b0;
    while (n < K + 4 && !got) begin
      if (inject && n == inj_at) begin
        start = 1'b1;
        base = AW'(b + 5);
      end else begin
        start = 1'b0;
      end
      tick();
      n++;
      if (valid) got = 1;
    end
    start = 1'b0;
    chk(got && n == K + 1, "R3 latency", 64'(n), 64'(K + 1));
    chk(result == exp, {tag, " result"}, 64'(result), 64'(exp));
    tick();
    chk(!valid, "R3 single cycle valid", 64'(valid), 64'd0);
    chk(result == exp, "R4 result held", 64'(result), 64'(exp));
    if (inject) begin
      for (int j = 0; j < K + 2; j++) begin
        tick();
        chk(!valid, "R5 no extra valid", 64'(valid), 64'd0);
      end
      chk(result == exp, "R5 busy start ignored", 64'(result), 64'(exp));
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd77));
    rst = 1'b1;
    repeat (3) tick();
    chk(result == '0, "R6 reset result", 64'(result), 64'd0);
    chk(!valid, "R6 reset valid", 64'(valid), 64'd0);
    rst = 1'b0;
    tick();

    // R1: sweep the whole table through base 0..15 fetches.
    for (int b = 0; b < 16; b++) run_fetch(b, 0, 0, "R1 R2 table");
    // R2: wrap cases.
    run_fetch(14, 0, 0, "R2 wrap 14");
    run_fetch(15, 0, 0, "R2 wrap 15");
    run_fetch(3,  0, 0, "R2 base 3");
    // R5: busy start at every point of a fetch.
    for (int p = 0; p <= K; p++) run_fetch(2, 1, p, "R5 inject");

    // R7: back-to-back; start asserted right after valid is seen.
    begin
      int n = 0;
      base = 4'd1;
      start = 1'b1;
      tick();
      start = 1'b0;
      while (n < K + 4 && !valid) begin tick(); n++; end
      chk(valid && result == ref_result(1), "R7 first of pair", 64'(result), 64'(ref_result(1)));
      base = 4'd5;
      start = 1'b1;
      tick();
      start = 1'b0;
      n = 0;
      while (n < K + 4 && !valid) begin tick(); n++; end
      chk(n == K + 1, "R7 back-to-back latency", 64'(n), 64'(K + 1));
      chk(result == ref_result(5), "R7 back-to-back result", 64'(result), 64'(ref_result(5)));
      tick();
    end

    // R6: reset in the middle of a fetch.
    base = 4'd2;
    start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    tick();
    rst = 1'b1;
    tick();
    tick();
    chk(result == '0, "R6 mid-fetch reset result", 64'(result), 64'd0);
    chk(!valid, "R6 mid-fetch reset valid", 64'(valid), 64'd0);
    rst = 1'b0;
    for (int j = 0; j < K + 3; j++) begin
      tick();
      chk(!valid, "R6 fetch aborted", 64'(valid), 64'd0);
    end
    run_fetch(6, 0, 0, "R6 after reset");

    // Random mix.
    for (int t = 0; t < 40; t++) begin
      int b = int'($urandom_range(15, 0));
      bit inj = ($urandom_range(3, 0) == 0);
      int at = int'($urandom_range(K, 0));
      run_fetch(b, inj, at, "R2 random");
      if ($urandom_range(1, 0) == 1) tick();
    end

    done = 1'b1;
    finish_run();
  end
endmodule